// File: doc/BRIEF.md
# Console Run, Halt and Single-Step Controller

This block sits on the operator-console side of a small processor and decides, cycle by cycle, whether the processor clock may run. It takes a run-permit level (enable or halt), two push-button inputs (start and continue), a step-granularity level (whole instruction or single bus cycle), and two one-cycle strobes from the processor: end of bus cycle and end of instruction. It drives the clock enable, the run lamp, a system-initialise level and a one-cycle strobe that tells the program counter to take the start address last loaded from the console.

Holding start with the permit set keeps the system in initialisation. Releasing start begins execution, and the start-address load strobe is raised in the first cycle of the run. Pressing continue resumes without initialising. With the permit at halt, each press of continue grants either one whole instruction or one bus cycle, depending on the granularity level, and the processor then halts again. A flag reports whether the processor is halted on an instruction boundary. Examine and deposit logic elsewhere may act only while this flag is high.

Top module: `console_run_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the outputs are run_en=0, run_lamp=0, sys_init=0, pc_load=0 and at_boundary=1.
- R2: A rising edge of start_btn while halted with permit_en=1 raises sys_init from the next cycle. sys_init stays high and run_en stays low for as long as start_btn is held.
- R3: Releasing start_btn during initialisation drops sys_init and raises run_en from the next cycle. pc_load is high for exactly that first run cycle.
- R4: A start_btn press while permit_en=0 produces neither sys_init nor run_en. If permit_en falls during initialisation, the controller returns to halt without running.
- R5: A rising edge of cont_btn while halted with permit_en=1 raises run_en from the next cycle, with sys_init and pc_load kept low.
- R6: With permit_en=0 and step_cycle=0, a cont_btn press runs until the first instr_end strobe. run_en is low from the cycle after that strobe. A bus_end strobe alone does not stop it.
- R7: With permit_en=0 and step_cycle=1, a cont_btn press runs until the first bus_end strobe. run_en is low from the cycle after that strobe.
- R8: When permit_en falls during a free run, the processor keeps running until the strobe selected by step_cycle (instr_end for 0, bus_end for 1). At that strobe it halts if permit_en is still 0, and it keeps running if permit_en is 1 again.
- R9: at_boundary is 1 while halted only if the halt happened on an instr_end strobe, after reset, or after an aborted initialisation. A halt on a bus_end without instr_end leaves it 0. It is 0 whenever run_en or sys_init is 1.
- R10: Button presses are acted on only at their rising edge. A button that is held does not trigger again, and presses or releases during a free run are ignored.
- R11: run_lamp always equals run_en. Both come from the same run flip-flop.

The strobes are one clock wide and valid only while run_en=1. instr_end is raised only together with bus_end, on the last bus cycle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| permit_en | input | 1 | 1 = programs may run, 0 = halt requested |
| start_btn | input | 1 | Start push-button level |
| cont_btn | input | 1 | Continue push-button level |
| step_cycle | input | 1 | 0 = step and stop on instruction, 1 = on bus cycle |
| bus_end | input | 1 | Processor strobe: a bus cycle ends this cycle |
| instr_end | input | 1 | Processor strobe: an instruction ends this cycle |
| run_en | output | 1 | Processor clock enable |
| run_lamp | output | 1 | Run indicator |
| sys_init | output | 1 | System initialise, held while start is held |
| pc_load | output | 1 | One-cycle strobe to load the start address |
| at_boundary | output | 1 | Halted at an instruction boundary (console access allowed) |

## Verification
A stop strobe and a change of the permit level can reach the controller in the same cycle. This decides whether a pending stop halts the processor or is withdrawn. The table drives permit_en back high in the very cycle that carries the matching strobe, and expects the run to continue without a gap. A bus-cycle strobe that coincides with an instruction end in step-cycle mode is also driven. In that case the halt flag must come up, while the same stop without instr_end must leave it low.

// File: rtl/rc_pkg.sv
// Package: shared state encoding for the console run controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rc_pkg;
    typedef enum logic [2:0] {
        S_HALTED     = 3'd0,
        S_INIT_HELD  = 3'd1,
        S_RUNNING    = 3'd2,
        S_STEP_INST  = 3'd3,
        S_STEP_CYCLE = 3'd4,
        S_STOPPING   = 3'd5
    } rc_state_e;

    // True for every state in which the processor clock is enabled.
    function automatic logic rc_clocks(rc_state_e s);
        return (s == S_RUNNING) || (s == S_STOPPING) ||
               (s == S_STEP_INST) || (s == S_STEP_CYCLE);
    endfunction
endpackage

// File: rtl/rc_edge.sv
// Module: rising-edge detector for N push-button levels.
// Assumes: the inputs are already synchronous to clk. A button held
// through reset is seen as a fresh press once reset ends.
module rc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Remember last level of this button.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl[g];
        end
        // A press is high now and low one cycle ago.
        assign rise[g] = lvl[g] & ~prev_q[g];
    end
endmodule

// File: rtl/rc_fsm.sv
// Module: run/halt/step sequencer.
// Assumes: start_rise and cont_rise are one-cycle press pulses. bus_end and
// instr_end are one-cycle strobes valid only while the clock is enabled.
module rc_fsm
    import rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      permit_en,
    input  logic      start_lvl,
    input  logic      start_rise,
    input  logic      cont_rise,
    input  logic      step_cycle,
    input  logic      bus_end,
    input  logic      instr_end,
    output rc_state_e state,
    output rc_state_e nxt
);
    logic stop_strobe;

    // The boundary strobe that matches the selected granularity.
    assign stop_strobe = step_cycle ? bus_end : instr_end;

    // Next-state decision.
    always_comb begin
        nxt = state;
        unique case (state)
            S_HALTED: begin
                if (start_rise && permit_en)   nxt = S_INIT_HELD;
                else if (cont_rise) begin
                    if (permit_en)             nxt = S_RUNNING;
                    else if (step_cycle)       nxt = S_STEP_CYCLE;
                    else                       nxt = S_STEP_INST;
                end
            end
            S_INIT_HELD: begin
                if (!permit_en)                nxt = S_HALTED;
                else if (!start_lvl)           nxt = S_RUNNING;
            end
            S_RUNNING: begin
                if (!permit_en)                nxt = S_STOPPING;
            end
            S_STOPPING: begin
                if (stop_strobe)               nxt = permit_en ? S_RUNNING : S_HALTED;
            end
            S_STEP_INST: begin
                if (instr_end)                 nxt = S_HALTED;
            end
            S_STEP_CYCLE: begin
                if (bus_end)                   nxt = S_HALTED;
            end
            default:                           nxt = S_HALTED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HALTED;
        else        state <= nxt;
    end

    AST_HALT_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALTED && start_rise && !permit_en && !cont_rise) |=> (state == S_HALTED)); // R4
    AST_STEP_INST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP_INST && instr_end) |=> (state == S_HALTED)); // R6
    AST_STEP_CYC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP_CYCLE && bus_end) |=> (state == S_HALTED)); // R7
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUNNING && permit_en) |=> (state == S_RUNNING)); // R10
    AST_STOP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOPPING && !stop_strobe) |=> (state == S_STOPPING)); // R8
endmodule

// File: rtl/rc_outs.sv
// Module: output flip-flops of the run controller.
// Assumes: nxt is the sequencer's next state, so every output is a
// register aligned with the state register.
module rc_outs
    import rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rc_state_e state,
    input  rc_state_e nxt,
    input  logic      bus_end,
    input  logic      instr_end,
    output logic      run_q,
    output logic      init_q,
    output logic      pcl_q,
    output logic      bound_q
);
    // Run flip-flop: the processor clock enable and the lamp source.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= rc_clocks(nxt);
    end

    // Initialise level, high while in the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) init_q <= 1'b0;
        else        init_q <= (nxt == S_INIT_HELD);
    end

    // Start-address load pulse on the hold-to-run transition.
    always_ff @(posedge clk) begin
        if (!rst_n) pcl_q <= 1'b0;
        else        pcl_q <= (state == S_INIT_HELD) && (nxt == S_RUNNING);
    end

    // Instruction-boundary flag, decided at the moment of halting.
    always_ff @(posedge clk) begin
        if (!rst_n) bound_q <= 1'b1;
        else if (nxt == S_HALTED) begin
            if (state == S_INIT_HELD)   bound_q <= 1'b1;
            else if (state != S_HALTED) bound_q <= instr_end;
        end
        else bound_q <= 1'b0;
    end

    AST_INIT_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |-> !run_q); // R2
    AST_PCL_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        pcl_q |-> (run_q && $past(init_q))); // R3
    AST_CYC_STOP_NO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP_CYCLE && bus_end && !instr_end) |=> !bound_q); // R9
    AST_BOUND_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q || init_q) |-> !bound_q); // R9
endmodule

// File: rtl/console_run_ctrl.sv
// Module: console run controller top. Joins the press detector, the
// sequencer and the output registers.
// Assumes: all inputs synchronous to clk. instr_end only together with bus_end.
module console_run_ctrl
    import rc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic permit_en,
    input  logic start_btn,
    input  logic cont_btn,
    input  logic step_cycle,
    input  logic bus_end,
    input  logic instr_end,
    output logic run_en,
    output logic run_lamp,
    output logic sys_init,
    output logic pc_load,
    output logic at_boundary
);
    localparam int NBTN    = 2;
    localparam int B_START = 0;
    localparam int B_CONT  = 1;

    logic [NBTN-1:0] btn_lvl;
    logic [NBTN-1:0] btn_rise;
    rc_state_e       state;
    rc_state_e       nxt;
    logic            run_q;

    assign btn_lvl[B_START] = start_btn;
    assign btn_lvl[B_CONT]  = cont_btn;

    rc_edge #(.N(NBTN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (btn_lvl),
        .rise (btn_rise)
    );

    rc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .permit_en (permit_en),
        .start_lvl (start_btn),
        .start_rise(btn_rise[B_START]),
        .cont_rise (btn_rise[B_CONT]),
        .step_cycle(step_cycle),
        .bus_end   (bus_end),
        .instr_end (instr_end),
        .state     (state),
        .nxt       (nxt)
    );

    rc_outs u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .nxt      (nxt),
        .bus_end  (bus_end),
        .instr_end(instr_end),
        .run_q    (run_q),
        .init_q   (sys_init),
        .pcl_q    (pc_load),
        .bound_q  (at_boundary)
    );

    // Clock enable and lamp share the one run flip-flop.
    assign run_en   = run_q;
    assign run_lamp = run_q;
endmodule

// File: tb/test_console_run_ctrl.sv
module test_console_run_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic permit_en = 1'b0, start_btn = 1'b0, cont_btn = 1'b0, step_cycle = 1'b0;
    logic bus_end = 1'b0, instr_end = 1'b0;
    logic run_en, run_lamp, sys_init, pc_load, at_boundary;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    console_run_ctrl i_console_run_ctrl (
        .clk(clk), .rst_n(rst_n), .permit_en(permit_en), .start_btn(start_btn),
        .cont_btn(cont_btn), .step_cycle(step_cycle), .bus_end(bus_end),
        .instr_end(instr_end), .run_en(run_en), .run_lamp(run_lamp),
        .sys_init(sys_init), .pc_load(pc_load), .at_boundary(at_boundary)
    );

    // Fields: req[13:10] en st co md cy in | run init pcl bound
    localparam int NV = 28;
    localparam logic [13:0] VEC [NV] = '{
        14'b0010_110000_0100, // 1  start press -> init
        14'b0010_110000_0100, // 2  still held
        14'b0011_100000_1010, // 3  release -> run + pc_load
        14'b1010_100010_1000, // 4  free run, strobe ignored
        14'b1010_111000_1000, // 5  presses while running ignored
        14'b1000_000000_1000, // 6  stop requested, still running
        14'b1000_000010_1000, // 7  bus end not enough in instr mode
        14'b1000_000011_0001, // 8  halts on instr end
        14'b0111_001100_1000, // 9  cont -> step cycle
        14'b0111_001110_0000, // 10 bus end halts, cont held no retrigger
        14'b1010_000100_0000, // 11 stays halted
        14'b0110_001000_1000, // 12 cont -> step instr
        14'b0110_000010_1000, // 13 bus end alone keeps stepping
        14'b0110_000011_0001, // 14 instr end halts
        14'b0100_010000_0001, // 15 start with halt permit ignored
        14'b0100_000000_0001, // 16 still halted
        14'b0101_101000_1000, // 17 cont with permit -> run, no init
        14'b0101_100000_1000, // 18 running
        14'b1000_000100_1000, // 19 stop in cycle mode
        14'b1001_000110_0000, // 20 halt mid-instruction, flag low
        14'b1001_000000_0000, // 21 still halted, flag low
        14'b1001_001100_1000, // 22 step cycle
        14'b1001_000111_0001, // 23 cycle ends with instruction -> flag high
        14'b0101_101000_1000, // 24 run again
        14'b1000_000000_1000, // 25 stop request
        14'b1000_100000_1000, // 26 permit back, no strobe yet
        14'b1000_100011_1000, // 27 permit high at strobe -> keep running
        14'b1000_100000_1000  // 28 running
    };

    function automatic string rname(logic [3:0] id);
        case (id)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: run/init/pcl/bound actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(logic [5:0] v);
        {permit_en, start_btn, cont_btn, step_cycle, bus_end, instr_end} = v;
    endtask

    task automatic step_and_check(string req, logic [5:0] v, logic [3:0] exp);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
        check(req, {run_en, sys_init, pc_load, at_boundary}, exp);
        total++;
        if (run_lamp !== run_en) begin
            bad++;
            $display("FAIL R11: run_lamp actual=%b expected=%b", run_lamp, run_en);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R1", {run_en, sys_init, pc_load, at_boundary}, 4'b0001);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            step_and_check(rname(VEC[i][13:10]), VEC[i][9:4], VEC[i][3:0]);

        // R1: reset in the middle of a free run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {run_en, sys_init, pc_load, at_boundary}, 4'b0001);
        @(negedge clk);
        drive(6'b000000);
        rst_n = 1'b1;

        // R2: long start hold keeps init and no run
        step_and_check("R2", 6'b110000, 4'b0100);
        for (int k = 0; k < 10; k++) step_and_check("R2", 6'b110000, 4'b0100);
        // R4: permit drops during init -> halted without running
        step_and_check("R4", 6'b010000, 4'b0001);
        step_and_check("R4", 6'b000000, 4'b0001);
        // R10: cont held high over many cycles in step mode gives one step only
        step_and_check("R10", 6'b001000, 4'b1000);
        step_and_check("R10", 6'b001011, 4'b0001);
        for (int k = 0; k < 4; k++) step_and_check("R10", 6'b001000, 4'b0001);
        // R5: start release after a cont-run does not pulse pc_load
        step_and_check("R5", 6'b100000, 4'b0001);
        step_and_check("R5", 6'b101000, 4'b1000);
        step_and_check("R5", 6'b100000, 4'b1000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule